// File: doc/BRIEF.md
# Single-Cycle Subset RISC Core

This block is a 32-bit processor core that finishes each instruction in one clock cycle. It decodes a nine-instruction subset: register-to-register add, subtract, and, or and signed set-less-than, word load and word store, branch-if-equal and an unconditional jump. The core holds the program counter, a register file, the ALU, the immediate sign extender, the branch and jump target logic and the datapath multiplexers. Its control is a purely combinational decode of the current instruction word.

The core fetches through a read-only instruction port. The instruction address is the program counter, and the instruction word returns combinationally in the same cycle. Loads and stores use a data port that has an address, write data, read data and separate read and write enables. The memory returns read data combinationally. A store is committed on the rising edge that ends the cycle. The PC, the register file and data memory all update together on that edge.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter, and so `instAddr`, to 0 on the rising edge where `rst` is high.
- R2: For every instruction other than a taken branch or a jump, the next PC is the current PC plus 4.
- R3: With opcode 0x00, funct 0x20 / 0x22 / 0x24 / 0x25 writes rs+rt, rs-rt, rs AND rt or rs OR rt into rd (bits 15:11). rs is bits 25:21 and rt is bits 20:16.
- R4: With opcode 0x00 and funct 0x2A, rd receives 1 when rs is less than rt as signed two's-complement numbers, and 0 otherwise.
- R5: Opcode 0x23 (load) drives `dataAddr` = rs + sign-extended bits 15:0 and raises `dataRe`. It writes `dataRdata` into rt.
- R6: Opcode 0x2B (store) drives `dataAddr` = rs + sign-extended bits 15:0 and `dataWdata` = rt, raises `dataWe`, and writes no register.
- R7: Opcode 0x04 (branch-if-equal) with rs equal to rt sets the next PC to PC+4 + (sign-extended bits 15:0 shifted left by 2). This covers negative offsets.
- R8: Opcode 0x04 with rs not equal to rt leaves the next PC at PC+4.
- R9: Opcode 0x02 (jump) sets the next PC to {PC+4 bits 31:28, instruction bits 25:0, 2'b00}.
- R10: Register 0 reads as zero, and a write that targets it has no effect.
- R11: Any other opcode, or opcode 0x00 with any other funct, writes no register and no memory and advances the PC by 4.
- R12: `dataWe` is high only for a store, and `dataWe` and `dataRe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instAddr | output | 32 | Instruction fetch address (program counter) |
| instData | input | 32 | Instruction word at `instAddr`, combinational |
| dataAddr | output | 32 | Data memory byte address for load or store |
| dataWdata | output | 32 | Store data |
| dataRdata | input | 32 | Load data at `dataAddr`, combinational |
| dataRe | output | 1 | Load in progress this cycle |
| dataWe | output | 1 | Store to commit on the coming rising edge |

## Verification
The program uses a negative load offset to reach address 0 from a non-zero base. A core that zero-extended immediates would present a far address and load the wrong value, and a later store would expose that value. It takes a forward branch, skips one not taken, and finally loops on a backward branch with offset -1. A core that forgot the PC+4 base or the shift by 2 would fetch from a wrong address that the per-cycle PC comparison catches. Signed set-less-than is applied to a negative and a positive operand in both orders, which separates a signed compare from an unsigned one. A write to register 0 is followed by a store of register 0. An undecoded opcode whose rt field names a live register is followed by a store of that register, so a core that let either write through would store a wrong value.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } aluFn_e;

  // Coarse ALU class chosen by the main decode; refined by funct for R-type
  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aluOp_e;

  typedef struct packed {
    logic   regDst;    // 1: write rd, 0: write rt
    logic   aluSrc;    // 1: immediate operand, 0: rt value
    logic   memToReg;  // 1: write back load data
    logic   regWrite;
    logic   memRead;
    logic   memWrite;
    logic   branch;
    logic   jump;
    aluOp_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/sc_core_ctrl.sv
module sc_core_ctrl
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output aluFn_e     aluFn
);

  logic functKnown;

  always_comb begin
    unique case (funct)
      FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT: functKnown = 1'b1;
      default:                               functKnown = 1'b0;
    endcase
  end

  // Main decode: one strobe set per opcode, all-quiet for anything else
  always_comb begin
    ctrl = '{regDst: 1'b0, aluSrc: 1'b0, memToReg: 1'b0, regWrite: 1'b0,
             memRead: 1'b0, memWrite: 1'b0, branch: 1'b0, jump: 1'b0,
             aluOp: AOP_ADD};
    case (opcode)
      OP_RTYPE: begin
        ctrl.regDst   = 1'b1;
        ctrl.regWrite = functKnown;
        ctrl.aluOp    = AOP_FUNCT;
      end
      OP_LOAD: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.memRead  = 1'b1;
      end
      OP_STORE: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = AOP_SUB;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

  // Second-level ALU decode
  always_comb begin
    aluFn = ALU_ADD;
    case (ctrl.aluOp)
      AOP_SUB: aluFn = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_SUB:  aluFn = ALU_SUB;
          FN_AND:  aluFn = ALU_AND;
          FN_OR:   aluFn = ALU_OR;
          FN_SLT:  aluFn = ALU_SLT;
          default: aluFn = ALU_ADD;
        endcase
      end
      default: aluFn = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_core_regfile.sv
module sc_core_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic [AW-1:0]   rdAddrA,
  input  logic [AW-1:0]   rdAddrB,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB,
  input  logic            wrEn,
  input  logic [AW-1:0]   wrAddr,
  input  logic [XLEN-1:0] wrData
);

  logic [XLEN-1:0] regs [NREGS];

  // Entry 0 is never stored; it is forced to zero on read
  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr != '0)) regs[wrAddr] <= wrData;
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
  import sc_core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  aluFn_e          fn,
  output logic [XLEN-1:0] result,
  output logic            zero
);

  always_comb begin
    case (fn)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = opA + opB;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/sc_core_datapath.sv
module sc_core_datapath
  import sc_core_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrl,
  input  aluFn_e          aluFn,
  input  logic [31:0]     instData,
  input  logic [XLEN-1:0] dataRdata,
  output logic [XLEN-1:0] instAddr,
  output logic [XLEN-1:0] dataAddr,
  output logic [XLEN-1:0] dataWdata,
  output logic [5:0]      opcode,
  output logic [5:0]      funct
);

  localparam int REG_AW = $clog2(NREGS);
  localparam int IMM_W  = 16;
  localparam int JMP_W  = 26;

  logic [XLEN-1:0] pc, pcPlus4, branchTarget, jumpTarget, nextPc;
  logic [XLEN-1:0] rsVal, rtVal, immExt, aluB, aluResult, writeBack;
  logic [4:0]      rsIdx, rtIdx, rdIdx;
  logic [IMM_W-1:0] imm;
  logic [REG_AW-1:0] destIdx;
  logic            aluZero, takeBranch;

  assign opcode = instData[31:26];
  assign rsIdx  = instData[25:21];
  assign rtIdx  = instData[20:16];
  assign rdIdx  = instData[15:11];
  assign funct  = instData[5:0];
  assign imm    = instData[IMM_W-1:0];

  assign immExt  = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign destIdx = ctrl.regDst ? rdIdx[REG_AW-1:0] : rtIdx[REG_AW-1:0];

  sc_core_regfile #(.XLEN(XLEN), .NREGS(NREGS)) regFileI (
    .clk     (clk),
    .rdAddrA (rsIdx[REG_AW-1:0]),
    .rdAddrB (rtIdx[REG_AW-1:0]),
    .rdDataA (rsVal),
    .rdDataB (rtVal),
    .wrEn    (ctrl.regWrite),
    .wrAddr  (destIdx),
    .wrData  (writeBack)
  );

  assign aluB = ctrl.aluSrc ? immExt : rtVal;

  sc_core_alu #(.XLEN(XLEN)) aluI (
    .opA    (rsVal),
    .opB    (aluB),
    .fn     (aluFn),
    .result (aluResult),
    .zero   (aluZero)
  );

  assign writeBack = ctrl.memToReg ? dataRdata : aluResult;

  // Next-PC selection
  assign pcPlus4      = pc + XLEN'(4);
  assign branchTarget = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jumpTarget   = {pcPlus4[XLEN-1:JMP_W+2], instData[JMP_W-1:0], 2'b00};
  assign takeBranch   = ctrl.branch & aluZero;

  always_comb begin
    if (ctrl.jump)       nextPc = jumpTarget;
    else if (takeBranch) nextPc = branchTarget;
    else                 nextPc = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= nextPc;
  end

  assign instAddr  = pc;
  assign dataAddr  = aluResult;
  assign dataWdata = rtVal;

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] instAddr,
  input  logic [31:0]     instData,
  output logic [XLEN-1:0] dataAddr,
  output logic [XLEN-1:0] dataWdata,
  input  logic [XLEN-1:0] dataRdata,
  output logic            dataRe,
  output logic            dataWe
);

  ctrl_t      ctrl;
  aluFn_e     aluFn;
  logic [5:0] opcode, funct;

  sc_core_ctrl ctrlI (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl),
    .aluFn  (aluFn)
  );

  sc_core_datapath #(.XLEN(XLEN), .NREGS(NREGS)) dpI (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .aluFn     (aluFn),
    .instData  (instData),
    .dataRdata (dataRdata),
    .instAddr  (instAddr),
    .dataAddr  (dataAddr),
    .dataWdata (dataWdata),
    .opcode    (opcode),
    .funct     (funct)
  );

  assign dataRe = ctrl.memRead;
  assign dataWe = ctrl.memWrite;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] instAddr,
  input logic [31:0]     instData,
  input logic            dataRe,
  input logic            dataWe
);

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> (instAddr == '0));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((instData[31:26] != 6'h04) && (instData[31:26] != 6'h02))
      |=> (instAddr == $past(instAddr) + XLEN'(4)));

  // R9
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (instData[31:26] == 6'h02)
      |=> (instAddr[27:0] == {$past(instData[25:0]), 2'b00}));

  // R12
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dataWe |-> (instData[31:26] == 6'h2B));

  // R12
  enable_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dataWe && dataRe));

  // R5
  load_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (instData[31:26] == 6'h23) |-> (dataRe && !dataWe));

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) chkI (
  .clk      (clk),
  .rst      (rst),
  .instAddr (instAddr),
  .instData (instData),
  .dataRe   (dataRe),
  .dataWe   (dataWe)
);

// File: tb/sc_core_test.sv
module sc_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instAddr, instData, dataAddr, dataWdata, dataRdata;
  logic        dataRe, dataWe;

  logic [31:0] imem [MEM_WORDS];
  logic [31:0] dmem [MEM_WORDS];

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic [31:0] pc;
    logic        re;
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core uut (
    .clk       (clk),
    .rst       (rst),
    .instAddr  (instAddr),
    .instData  (instData),
    .dataAddr  (dataAddr),
    .dataWdata (dataWdata),
    .dataRdata (dataRdata),
    .dataRe    (dataRe),
    .dataWe    (dataWe)
  );

  // Behavioural memories
  assign instData  = imem[instAddr[7:2]];
  assign dataRdata = dmem[dataAddr[7:2]];
  always @(posedge clk) if (dataWe) dmem[dataAddr[7:2]] <= dataWdata;

  function automatic logic [31:0] encR(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input logic [15:0] im);
    return {op, 5'(rs), 5'(rt), im};
  endfunction

  function automatic logic [31:0] encJ(input logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Driver side: record what each executed cycle should present
  task automatic pushExp(input logic [31:0] pc, input logic re, input logic we,
                         input logic [31:0] addr, input logic [31:0] data, input string tag);
    exp_t e;
    e.pc = pc; e.re = re; e.we = we; e.addr = addr; e.data = data; e.tag = tag;
    expQ.push_back(e);
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    dmem[0] = 32'd5;
    dmem[1] = 32'hFFFF_FFFD;
    imem[0]  = encI(6'h23, 0, 1, 16'd0);        // r1 = 5
    imem[1]  = encI(6'h23, 0, 2, 16'd4);        // r2 = -3
    imem[2]  = encR(1, 2, 3, 6'h20);            // r3 = 2
    imem[3]  = encI(6'h2B, 0, 3, 16'd16);
    imem[4]  = encR(1, 2, 4, 6'h22);            // r4 = 8
    imem[5]  = encI(6'h2B, 0, 4, 16'd20);
    imem[6]  = encR(1, 2, 5, 6'h24);            // r5 = 5
    imem[7]  = encR(1, 2, 6, 6'h25);            // r6 = -3
    imem[8]  = encI(6'h2B, 0, 5, 16'd24);
    imem[9]  = encI(6'h2B, 0, 6, 16'd28);
    imem[10] = encR(2, 1, 7, 6'h2A);            // r7 = 1
    imem[11] = encR(1, 2, 8, 6'h2A);            // r8 = 0
    imem[12] = encI(6'h2B, 0, 7, 16'd32);
    imem[13] = encI(6'h2B, 0, 8, 16'd36);
    imem[14] = encR(1, 1, 0, 6'h20);            // write to r0
    imem[15] = encI(6'h2B, 0, 0, 16'd40);
    imem[16] = encI(6'h23, 4, 9, 16'hFFF8);     // r9 = mem[8-8] = 5
    imem[17] = encI(6'h2B, 0, 9, 16'd44);
    imem[18] = encI(6'h04, 1, 2, 16'd5);        // not taken
    imem[19] = encI(6'h04, 1, 9, 16'd2);        // taken to 88
    imem[20] = encI(6'h2B, 0, 1, 16'd48);
    imem[21] = encI(6'h2B, 0, 1, 16'd52);
    imem[22] = encJ(26'd26);                    // to 104
    imem[23] = encI(6'h2B, 0, 1, 16'd60);
    imem[26] = encI(6'h08, 0, 1, 16'd7);        // undecoded opcode, rt = r1
    imem[27] = encI(6'h2B, 0, 1, 16'd56);
    imem[28] = encI(6'h04, 0, 0, 16'hFFFF);     // spin at 112
  end

  initial begin
    pushExp(32'd0,   1, 0, 32'd0,  32'd0, "R5 load");
    pushExp(32'd4,   1, 0, 32'd4,  32'd0, "R5 load");
    pushExp(32'd8,   0, 0, 32'd0,  32'd0, "R2 step");
    pushExp(32'd12,  0, 1, 32'd16, 32'd2, "R3 add");
    pushExp(32'd16,  0, 0, 32'd0,  32'd0, "R2 step");
    pushExp(32'd20,  0, 1, 32'd20, 32'd8, "R3 sub");
    pushExp(32'd24,  0, 0, 32'd0,  32'd0, "R2 step");
    pushExp(32'd28,  0, 0, 32'd0,  32'd0, "R2 step");
    pushExp(32'd32,  0, 1, 32'd24, 32'd5, "R3 and");
    pushExp(32'd36,  0, 1, 32'd28, 32'hFFFF_FFFD, "R3 or");
    pushExp(32'd40,  0, 0, 32'd0,  32'd0, "R2 step");
    pushExp(32'd44,  0, 0, 32'd0,  32'd0, "R2 step");
    pushExp(32'd48,  0, 1, 32'd32, 32'd1, "R4 slt true");
    pushExp(32'd52,  0, 1, 32'd36, 32'd0, "R4 slt false");
    pushExp(32'd56,  0, 0, 32'd0,  32'd0, "R10 r0 write");
    pushExp(32'd60,  0, 1, 32'd40, 32'd0, "R10 r0 zero");
    pushExp(32'd64,  1, 0, 32'd0,  32'd0, "R5 negative offset");
    pushExp(32'd68,  0, 1, 32'd44, 32'd5, "R6 store");
    pushExp(32'd72,  0, 0, 32'd0,  32'd0, "R8 not taken");
    pushExp(32'd76,  0, 0, 32'd0,  32'd0, "R8 not taken");
    pushExp(32'd88,  0, 0, 32'd0,  32'd0, "R7 forward taken");
    pushExp(32'd104, 0, 0, 32'd0,  32'd0, "R9 jump");
    pushExp(32'd108, 0, 1, 32'd56, 32'd5, "R11 undecoded");
    pushExp(32'd112, 0, 0, 32'd0,  32'd0, "R11 pc step");
    pushExp(32'd112, 0, 0, 32'd0,  32'd0, "R7 backward taken");
    pushExp(32'd112, 0, 0, 32'd0,  32'd0, "R7 backward taken");
  end

  // Monitor: one expected item per executed cycle
  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(instAddr == 32'd0, "R1 reset pc", instAddr, 32'd0);
    check(dataWe == 1'b0, "R12 no store in reset", {31'd0, dataWe}, 32'd0);
    rst = 1'b0;
    while (expQ.size() > 0) begin
      exp_t e;
      @(negedge clk);
      e = expQ.pop_front();
      check(instAddr == e.pc, {e.tag, " pc"}, instAddr, e.pc);
      check(dataRe == e.re, {e.tag, " dataRe"}, {31'd0, dataRe}, {31'd0, e.re});
      check(dataWe == e.we, {e.tag, " R12 dataWe"}, {31'd0, dataWe}, {31'd0, e.we});
      if (e.we || e.re) check(dataAddr == e.addr, {e.tag, " addr"}, dataAddr, e.addr);
      if (e.we)         check(dataWdata == e.data, {e.tag, " wdata"}, dataWdata, e.data);
    end
    // Reset from mid-run
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(instAddr == 32'd0, "R1 reset mid-run", instAddr, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule